// File: doc/BRIEF.md
# Character-Clocked Raster Timing Generator

This block drives the horizontal and vertical timing of a raster display. It counts characters of eight pixels along a line and lines down a frame, and from these two counts it produces display-enable, blanking, horizontal and vertical sync, a line-compare strobe and the current line number. A character-clock enable paces both counters. When the enable is low, every count and timing flag holds.

Software programs the timing through a small write port. Totals and end positions are stored with fixed offsets from the true counts. The sync-end and blank-end values are short fields, each compared only against the low bits of its counter. Timing writes go into a shadow copy, which is loaded as a whole on the edge that starts a new frame, so a frame never runs on mixed settings. Sync polarity and the power-management controls act at once. The power controls can force either sync to its inactive level and can turn the screen dark while the counters keep running.

Top module: `crtc_timing`

## Requirements
- R1: A line has htot+5 characters, counted 0 to htot+4. Display-enable is high only while the character count is at most hde and the line count is at most vde.
- R2: A frame has vtot+2 lines, counted 0 to vtot+1. `line_o` always shows the current line count.
- R3: Horizontal sync starts at the character equal to hss. It ends at the next character whose count has low 5 bits equal to hse. The end test wins over the start test, so a pulse lasts (hse-hss) mod 32 characters, at most 31, and equal low bits give no pulse.
- R4: The blank window starts at character hde+1. It runs, continuing into the next line if needed, up to but not including the first character whose count has low 6 bits equal to hbe. `blank_o` is high outside the active area, inside that window, or while the screen is off.
- R5: Vertical sync starts at line vss. It ends at the next line whose count has low 4 bits equal to vse, with the end test winning. A pulse lasts at most 15 lines.
- R6: Bit 6 of the polarity register makes horizontal sync active-low, and bit 7 makes vertical sync active-low. When a bit is clear, that sync is active-high. Writes to this register apply on the next clock.
- R7: In the power register, bit 7 holds horizontal sync at its inactive level and bit 6 holds vertical sync at its inactive level. Bit 5 forces display-enable low and blanking high. The counters keep running in every case, and writes apply on the next clock.
- R8: `lc_stb_o` is high for exactly one clock after each step of the line counter onto the value lcmp. This includes the step from the last line back to line 0.
- R9: On a clock where `ce_i` is low, the counters, sync flags and blank window hold their values.
- R10: The register addresses are 0 htot, 1 hde, 2 hss, 3 hse, 4 hbe, 5 vtot, 6 vde, 7 vss, 8 vse, 9 lcmp, 10 polarity, 11 power. Other addresses are ignored. Registers 0 to 9 take effect together on the clock where the count wraps from the last character of the last line to 0.
- R11: During reset both counts are 0 and the timing registers hold their defaults: htot 3, hde 4, hss 5, hse 7, hbe 7, vtot 4, vde 2, vss 3, vse 5, lcmp 1. Polarity and power are 0, so display-enable is 1 and blanking, both syncs and the strobe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Character-clock enable |
| wr_i | input | 1 | Register write strobe |
| waddr_i | input | 4 | Register address |
| wdata_i | input | 11 | Register write data |
| de_o | output | 1 | Display enable |
| blank_o | output | 1 | Blanking |
| hsync_o | output | 1 | Horizontal sync, with polarity and power gating applied |
| vsync_o | output | 1 | Vertical sync, with polarity and power gating applied |
| lc_stb_o | output | 1 | Line-compare strobe |
| line_o | output | 11 | Current line count |

## Verification
The hardest case to reach from the ports is a write sequence that straddles a frame boundary. In that case the wrap loads a shadow copy holding only part of the new settings, and the full set arrives only one frame later. The bench writes its register sequences while the character enable keeps toggling, so some writes land across a wrap. A model of the shadow and active copies predicts both the mixed frame and the following frame, including line counts. Short end fields are also exercised with windows that run past the end of a line, a 31-character sync, a 15-line sync and a zero-width sync.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int unsigned AW       = 4;
  localparam int unsigned DW       = 11;
  localparam int unsigned HW       = 9;
  localparam int unsigned VW       = 11;
  localparam int unsigned HSE_W    = 5;
  localparam int unsigned HBE_W    = 6;
  localparam int unsigned VSE_W    = 4;
  localparam int unsigned HTOT_OFS = 5;
  localparam int unsigned VTOT_OFS = 2;
  localparam int unsigned HCW      = HW + 1;
  localparam int unsigned VCW      = VW + 1;

  typedef enum logic [AW-1:0] {
    RA_HTOT = 4'd0, RA_HDE  = 4'd1, RA_HSS = 4'd2, RA_HSE  = 4'd3,
    RA_HBE  = 4'd4, RA_VTOT = 4'd5, RA_VDE = 4'd6, RA_VSS  = 4'd7,
    RA_VSE  = 4'd8, RA_LCMP = 4'd9, RA_POL = 4'd10, RA_PWR = 4'd11
  } reg_addr_e;

  typedef struct packed {
    logic [HW-1:0]    htot;
    logic [HW-1:0]    hde;
    logic [HW-1:0]    hss;
    logic [HSE_W-1:0] hse;
    logic [HBE_W-1:0] hbe;
    logic [VW-1:0]    vtot;
    logic [VW-1:0]    vde;
    logic [VW-1:0]    vss;
    logic [VSE_W-1:0] vse;
    logic [VW-1:0]    lcmp;
  } timing_t;

  localparam timing_t TIMING_RST = '{
    htot: HW'(3), hde: HW'(4), hss: HW'(5), hse: HSE_W'(7), hbe: HBE_W'(7),
    vtot: VW'(4), vde: VW'(2), vss: VW'(3), vse: VSE_W'(5), lcmp: VW'(1)
  };
endpackage

// File: rtl/crtc_regfile.sv
module crtc_regfile
  import crtc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          frame_start_i,
  output timing_t       act_o,
  output logic          hs_neg_o,
  output logic          vs_neg_o,
  output logic          hs_off_o,
  output logic          vs_off_o,
  output logic          scr_off_o
);
  timing_t shd_q, act_q;
  logic [1:0] pol_q;
  logic [2:0] pwr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q <= TIMING_RST;
      act_q <= TIMING_RST;
      pol_q <= '0;
      pwr_q <= '0;
    end else begin
      // shadow loads as a whole at frame start
      if (frame_start_i) act_q <= shd_q;
      if (wr_i) begin
        case (waddr_i)
          RA_HTOT: shd_q.htot <= wdata_i[HW-1:0];
          RA_HDE:  shd_q.hde  <= wdata_i[HW-1:0];
          RA_HSS:  shd_q.hss  <= wdata_i[HW-1:0];
          RA_HSE:  shd_q.hse  <= wdata_i[HSE_W-1:0];
          RA_HBE:  shd_q.hbe  <= wdata_i[HBE_W-1:0];
          RA_VTOT: shd_q.vtot <= wdata_i[VW-1:0];
          RA_VDE:  shd_q.vde  <= wdata_i[VW-1:0];
          RA_VSS:  shd_q.vss  <= wdata_i[VW-1:0];
          RA_VSE:  shd_q.vse  <= wdata_i[VSE_W-1:0];
          RA_LCMP: shd_q.lcmp <= wdata_i[VW-1:0];
          RA_POL:  pol_q      <= wdata_i[7:6];
          RA_PWR:  pwr_q      <= wdata_i[7:5];
          default: ;
        endcase
      end
    end
  end

  assign act_o     = act_q;
  assign hs_neg_o  = pol_q[0];
  assign vs_neg_o  = pol_q[1];
  assign scr_off_o = pwr_q[0];
  assign vs_off_o  = pwr_q[1];
  assign hs_off_o  = pwr_q[2];

  a_r10_apply_at_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(act_q));
endmodule

// File: rtl/crtc_hchan.sv
module crtc_hchan
  import crtc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic [HW-1:0]    htot_i,
  input  logic [HW-1:0]    hde_i,
  input  logic [HW-1:0]    hss_i,
  input  logic [HSE_W-1:0] hse_i,
  input  logic [HBE_W-1:0] hbe_i,
  output logic             wrap_o,
  output logic             hact_o,
  output logic             hs_o,
  output logic             hbl_o
);
  logic [HCW-1:0] hc_q, hc_n, h_end, bl_start;
  logic           at_end, hs_q, hbl_q;

  assign h_end    = HCW'(htot_i) + HCW'(HTOT_OFS - 1);
  assign bl_start = HCW'(hde_i) + HCW'(1);
  assign at_end   = hc_q >= h_end;
  assign hc_n     = at_end ? '0 : hc_q + HCW'(1);
  assign wrap_o   = ce_i & at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hc_q  <= '0;
      hs_q  <= 1'b0;
      hbl_q <= 1'b0;
    end else if (ce_i) begin
      hc_q <= hc_n;
      // end match beats start match
      if (hc_n[HSE_W-1:0] == hse_i)    hs_q <= 1'b0;
      else if (hc_n == HCW'(hss_i))    hs_q <= 1'b1;
      if (hc_n[HBE_W-1:0] == hbe_i)    hbl_q <= 1'b0;
      else if (hc_n == bl_start)       hbl_q <= 1'b1;
    end
  end

  assign hact_o = hc_q <= HCW'(hde_i);
  assign hs_o   = hs_q;
  assign hbl_o  = hbl_q;

  a_r1_hc_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hc_q <= h_end);
  a_r3_hs_rise_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_q) |-> hc_q == HCW'(hss_i));
  a_r9_hold_without_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable(hc_q) && $stable(hs_q) && $stable(hbl_q));
endmodule

// File: rtl/crtc_vchan.sv
module crtc_vchan
  import crtc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hwrap_i,
  input  logic [VW-1:0]    vtot_i,
  input  logic [VW-1:0]    vde_i,
  input  logic [VW-1:0]    vss_i,
  input  logic [VSE_W-1:0] vse_i,
  input  logic [VW-1:0]    lcmp_i,
  output logic             vwrap_o,
  output logic             vact_o,
  output logic             vs_o,
  output logic             lc_stb_o,
  output logic [VW-1:0]    vc_o
);
  logic [VW-1:0]  vc_q, vc_n;
  logic [VCW-1:0] v_end;
  logic           at_end, vs_q, lc_q;

  assign v_end   = VCW'(vtot_i) + VCW'(VTOT_OFS - 1);
  assign at_end  = {1'b0, vc_q} >= v_end;
  assign vc_n    = at_end ? '0 : vc_q + VW'(1);
  assign vwrap_o = hwrap_i & at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vc_q <= '0;
      vs_q <= 1'b0;
      lc_q <= 1'b0;
    end else begin
      lc_q <= hwrap_i && (vc_n == lcmp_i);
      if (hwrap_i) begin
        vc_q <= vc_n;
        if (vc_n[VSE_W-1:0] == vse_i) vs_q <= 1'b0;
        else if (vc_n == vss_i)       vs_q <= 1'b1;
      end
    end
  end

  assign vact_o   = vc_q <= vde_i;
  assign vs_o     = vs_q;
  assign lc_stb_o = lc_q;
  assign vc_o     = vc_q;

  a_r8_lc_single_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lc_q |=> !lc_q);
  a_r8_lc_on_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lc_q) |-> vc_q == lcmp_i || $past(hwrap_i && at_end));
  a_r5_vs_rise_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vs_q) |-> vc_q == vss_i || $past(hwrap_i && at_end));
endmodule

// File: rtl/crtc_timing.sv
module crtc_timing
  import crtc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_i,
  input  logic          wr_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          de_o,
  output logic          blank_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          lc_stb_o,
  output logic [VW-1:0] line_o
);
  timing_t act;
  logic hs_neg, vs_neg, hs_off, vs_off, scr_off;
  logic hwrap, vwrap, hact, vact, hs, vs, hbl;

  crtc_regfile u_regs (
    .clk_i, .rst_ni, .wr_i, .waddr_i, .wdata_i,
    .frame_start_i(vwrap),
    .act_o(act), .hs_neg_o(hs_neg), .vs_neg_o(vs_neg),
    .hs_off_o(hs_off), .vs_off_o(vs_off), .scr_off_o(scr_off)
  );

  crtc_hchan u_h (
    .clk_i, .rst_ni, .ce_i,
    .htot_i(act.htot), .hde_i(act.hde), .hss_i(act.hss),
    .hse_i(act.hse), .hbe_i(act.hbe),
    .wrap_o(hwrap), .hact_o(hact), .hs_o(hs), .hbl_o(hbl)
  );

  crtc_vchan u_v (
    .clk_i, .rst_ni, .hwrap_i(hwrap),
    .vtot_i(act.vtot), .vde_i(act.vde), .vss_i(act.vss),
    .vse_i(act.vse), .lcmp_i(act.lcmp),
    .vwrap_o(vwrap), .vact_o(vact), .vs_o(vs),
    .lc_stb_o(lc_stb_o), .vc_o(line_o)
  );

  assign de_o    = hact & vact & ~scr_off;
  assign blank_o = ~(hact & vact) | hbl | scr_off;
  assign hsync_o = (hs & ~hs_off) ^ hs_neg;
  assign vsync_o = (vs & ~vs_off) ^ vs_neg;

  a_r7_dark_keeps_counting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scr_off && ce_i |=> !$stable(line_o) || !$past(hwrap) || $past(vwrap && act.vtot == '1));
endmodule

// File: tb/sim_crtc_timing.sv
module sim_crtc_timing;
  import crtc_pkg::*;

  logic clk_i = 1'b0, rst_ni = 1'b1, ce_i = 1'b0, wr_i = 1'b0;
  logic [AW-1:0] waddr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic de_o, blank_o, hsync_o, vsync_o, lc_stb_o;
  logic [VW-1:0] line_o;

  always #4 clk_i = ~clk_i;

  crtc_timing u0 (.*);

  typedef struct packed {
    int htot; int hde; int hss; int hse; int hbe;
    int vtot; int vde; int vss; int vse; int lc;
  } cfg_t;

  localparam cfg_t CFG_RST = '{3, 4, 5, 7, 7, 4, 2, 3, 5, 1};
  localparam cfg_t CFG_A   = '{5, 5, 7, 9, 8, 3, 2, 3, 4, 2};
  localparam cfg_t CFG_B   = '{3, 3, 4, 4, 1, 5, 3, 4, 6, 5};
  localparam cfg_t CFG_C   = '{35, 3, 5, 4, 37, 1, 0, 1, 2, 0};
  localparam cfg_t CFG_D   = '{0, 0, 1, 2, 2, 16, 1, 2, 1, 17};

  cfg_t act, pend;
  int mh, mv, fsc, fr, cyc, n_chk, n_fail;
  bit hneg, vneg, hoff, voff, soff, exp_lc, last_ce;
  bit hs_tab[64], hb_tab[64], vs_tab[64];

  task automatic chk(input bit ok, input string req, input int a, input int e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (line %0d char %0d)", req, a, e, mv, mh);
    end
  endtask

  // windows walked from start until the low-bit end match (R3, R4, R5)
  function automatic void fill();
    int h = act.htot + HTOT_OFS;
    int v = act.vtot + VTOT_OFS;
    int p;
    for (int i = 0; i < 64; i++) begin hs_tab[i] = 0; hb_tab[i] = 0; vs_tab[i] = 0; end
    p = act.hss % h;
    for (int k = 0; k < h; k++) begin
      if ((p & 31) == act.hse) break;
      hs_tab[p] = 1; p = (p + 1) % h;
    end
    p = (act.hde + 1) % h;
    for (int k = 0; k < h; k++) begin
      if ((p & 63) == act.hbe) break;
      hb_tab[p] = 1; p = (p + 1) % h;
    end
    p = act.vss % v;
    for (int k = 0; k < v; k++) begin
      if ((p & 15) == act.vse) break;
      vs_tab[p] = 1; p = (p + 1) % v;
    end
  endfunction

  task automatic check_outputs();
    bit ha = (mh <= act.hde);
    bit va = (mv <= act.vde);
    bit e_de = ha && va && !soff;
    bit e_bl = !(ha && va) || hb_tab[mh] || soff;
    bit e_hs = (hs_tab[mh] && !hoff) ^ hneg;
    bit e_vs = (vs_tab[mv] && !voff) ^ vneg;
    chk(int'(line_o) == mv, last_ce ? "R2,R10 line" : "R9 line hold", int'(line_o), mv);
    chk(de_o === e_de, "R1,R7 de", int'(de_o), int'(e_de));
    chk(lc_stb_o === exp_lc, "R8 line compare", int'(lc_stb_o), int'(exp_lc));
    if (fsc >= 1) begin
      chk(hsync_o === e_hs, "R3,R6,R7 hsync", int'(hsync_o), int'(e_hs));
      chk(vsync_o === e_vs, "R5,R6,R7 vsync", int'(vsync_o), int'(e_vs));
      chk(blank_o === e_bl, "R4,R7 blank", int'(blank_o), int'(e_bl));
    end
  endtask

  task automatic step(input bit ce, input bit wr, input int addr, input int data);
    int nv;
    ce_i = ce; wr_i = wr; waddr_i = AW'(addr); wdata_i = DW'(data);
    @(posedge clk_i);
    cyc++;
    exp_lc = 0;
    last_ce = ce;
    if (ce) begin
      if (mh >= act.htot + HTOT_OFS - 1) begin
        mh = 0;
        nv = (mv >= act.vtot + VTOT_OFS - 1) ? 0 : mv + 1;
        exp_lc = (nv == act.lc);
        if (nv == 0 && mv != 0 || (nv == 0 && act.vtot + VTOT_OFS == 1)) begin
          fr++;
          if (pend != act) begin act = pend; fill(); fsc = 0; end
          else fsc++;
        end
        mv = nv;
      end else mh++;
    end
    if (wr) begin
      case (addr)
        0: pend.htot = data;  1: pend.hde = data;  2: pend.hss = data;
        3: pend.hse = data;   4: pend.hbe = data;  5: pend.vtot = data;
        6: pend.vde = data;   7: pend.vss = data;  8: pend.vse = data;
        9: pend.lc = data;
        10: begin hneg = data[6]; vneg = data[7]; end
        11: begin hoff = data[7]; voff = data[6]; soff = data[5]; end
        default: ;
      endcase
    end
    @(negedge clk_i);
    check_outputs();
  endtask

  function automatic bit ce_of(input int mode);
    return (mode == 0) ? 1'b1 : ((cyc % 3) != 2);
  endfunction

  task automatic run_frames(input int n, input int mode);
    int f0 = fr;
    while (fr < f0 + n) step(ce_of(mode), 0, 0, 0);
  endtask

  task automatic prog(input cfg_t c, input int mode);
    int v[10];
    v = '{c.htot, c.hde, c.hss, c.hse, c.hbe, c.vtot, c.vde, c.vss, c.vse, c.lc};
    for (int i = 0; i < 10; i++) step(ce_of(mode), 1, i, v[i]);
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    act = CFG_RST; pend = CFG_RST; fill();
    #2 rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    // R11 reset state
    chk(de_o === 1'b1, "R11 reset de", int'(de_o), 1);
    chk(blank_o === 1'b0, "R11 reset blank", int'(blank_o), 0);
    chk(hsync_o === 1'b0, "R11 reset hsync", int'(hsync_o), 0);
    chk(vsync_o === 1'b0, "R11 reset vsync", int'(vsync_o), 0);
    chk(lc_stb_o === 1'b0, "R11 reset strobe", int'(lc_stb_o), 0);
    chk(line_o === '0, "R11 reset line", int'(line_o), 0);
    rst_ni = 1'b1;
    run_frames(3, 0);
    prog(CFG_A, 0);
    run_frames(3, 0);
    step(1, 1, 10, 'hC0); run_frames(1, 0);                    // R6 both active-low
    step(1, 1, 10, 'h40); step(1, 1, 11, 'h80); run_frames(1, 0); // R7 hsync held off
    step(1, 1, 11, 'h60); run_frames(1, 0);                    // R7 vsync off, screen dark
    step(1, 1, 11, 'h00); step(1, 1, 10, 'h00); step(1, 1, 12, 'h7FF);
    run_frames(1, 0);
    prog(CFG_B, 1);
    run_frames(3, 1);
    prog(CFG_C, 0);
    run_frames(3, 0);
    prog(CFG_D, 1);
    run_frames(3, 1);
    prog(CFG_A, 1);
    run_frames(2, 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule